// File: doc/BRIEF.md
# Register-file-pointer DMA channel

This block is a single DMA channel that moves one byte per peripheral request between a peripheral data register and a target. The target is either a location in a 256-byte internal register file or a byte in a 16-bit-addressed memory. The channel holds no persistent address or count of its own. For each request it fetches the current target address and the remaining-transfer count from register-file locations chosen by two pointer inputs. It performs the move and then writes the incremented address and the decremented count back to those same locations.

Bit 0 of the count pointer selects the target. When it is 1, the address and the count are single bytes forming one even/odd pair. When it is 0, they are two separate 16-bit pairs. Each 16-bit pair stores its high byte at the even location. A direction input selects whether the byte flows from the peripheral to the target or from the target to the peripheral. When a transfer leaves the count at zero, a sticky end-of-block flag is raised for the interrupt controller. The flag stays set until it is cleared.

Top module: `rfp_dma_channel`

## Requirements
- R1: With `cnt_ptr_i[0]`=1 (register-file target), the count byte is read from location `{cnt_ptr_i[7:1],1}` and the address byte from `{cnt_ptr_i[7:1],0}`. With `dir_i`=0, `per_wdata_i` is written into the register file at that address.
- R2: With `cnt_ptr_i[0]`=0 (memory target), the count is the pair at `{cnt_ptr_i[7:1],0}` (high) and `{cnt_ptr_i[7:1],1}` (low). The address is the pair at `{adr_ptr_i[7:1],0}` (high) and `{adr_ptr_i[7:1],1}` (low), so `adr_ptr_i[0]` has no effect. With `dir_i`=0, `per_wdata_i` is written to memory at that 16-bit address, and register-file and memory writes never coincide.
- R3: After each transfer, the address written back is the old address plus one, and the count written back is the old count minus one, both to the locations they were read from.
- R4: With `dir_i`=1, the byte at the target address is presented on `per_rdata_o` with `per_we_o`=1 in the acknowledge cycle only.
- R5: A memory address wraps from FFFFh to 0000h, and a register-file address wraps from FFh to 00h.
- R6: A request that finds a zero count is not acknowledged, and it changes neither the register file nor memory.
- R7: `eob_o` rises in the cycle after the acknowledge of a transfer whose written-back count is zero. It stays set until `eob_clr_i` is sampled high.
- R8: `ack_o` is high for exactly one cycle per transfer. Counting from the clock edge that samples the request, it rises at the 6th edge for a register-file transfer and at the 10th edge for a memory transfer.
- R9: After reset, `ack_o`, `per_we_o`, `eob_o`, `rf_we_o` and `mem_we_o` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_i | input | 1 | Peripheral transfer request |
| ack_o | output | 1 | One-cycle transfer acknowledge |
| dir_i | input | 1 | 0: peripheral to target, 1: target to peripheral |
| per_wdata_i | input | 8 | Byte from the peripheral data register |
| per_rdata_o | output | 8 | Byte for the peripheral data register |
| per_we_o | output | 1 | Load strobe for the peripheral data register |
| cnt_ptr_i | input | 8 | Count pointer; bit 0 selects the target (1 register file, 0 memory) |
| adr_ptr_i | input | 8 | Address-pair pointer (memory target only) |
| rf_addr_o | output | 8 | Register-file address |
| rf_rdata_i | input | 8 | Register-file read data (combinational from `rf_addr_o`) |
| rf_we_o | output | 1 | Register-file write enable |
| rf_wdata_o | output | 8 | Register-file write data |
| mem_addr_o | output | 16 | Memory address |
| mem_rdata_i | input | 8 | Memory read data (combinational from `mem_addr_o`) |
| mem_re_o | output | 1 | Memory read strobe |
| mem_we_o | output | 1 | Memory write enable |
| mem_wdata_o | output | 8 | Memory write data |
| eob_o | output | 1 | End-of-block interrupt flag |
| eob_clr_i | input | 1 | Clears the end-of-block flag |

## Verification
The bench aims at the address wraps at FFh and FFFFh. A design that carried into the wrong byte, or let a register-file address spill into the high byte, would write back a wrong pointer value. It also drives a 16-bit count of 0100h, whose low byte is zero, so a design that looked only at the low byte would refuse the transfer or misborrow. Zero counts in both modes check that nothing is acknowledged or written, and odd address pointers check that pointer bit 0 is ignored. Counts of one check that the end-of-block flag rises, holds through idle cycles and clears only on request.

// File: rtl/rfp_dma_pkg.sv
// Shared types for the register-file-pointer DMA channel.
// Assumes: one byte moved per request; the sequencer steps through these states in order.
package rfp_dma_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CNT_H,
        ST_CNT_L,
        ST_ADR_H,
        ST_ADR_L,
        ST_XFER,
        ST_WB_AH,
        ST_WB_AL,
        ST_WB_CH,
        ST_WB_CL,
        ST_ACK
    } dma_state_e;

endpackage

// File: rtl/rfp_dma_fsm.sv
// Transfer sequencer: walks fetch, move, write-back and acknowledge.
// Assumes: rf_mode_i is valid in every state (the top supplies it live in IDLE and latched after);
// cnt_zero_i is only looked at in ST_CNT_L.
module rfp_dma_fsm
    import rfp_dma_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_i,
    input  logic       rf_mode_i,
    input  logic       cnt_zero_i,
    output dma_state_e state_o
);

    dma_state_e state_q, state_d;

    // Next-state selection for one transfer.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (req_i) state_d = rf_mode_i ? ST_CNT_L : ST_CNT_H;
            ST_CNT_H: state_d = ST_CNT_L;
            ST_CNT_L: begin
                if (cnt_zero_i)     state_d = ST_IDLE;
                else if (rf_mode_i) state_d = ST_ADR_L;
                else                state_d = ST_ADR_H;
            end
            ST_ADR_H: state_d = ST_ADR_L;
            ST_ADR_L: state_d = ST_XFER;
            ST_XFER:  state_d = rf_mode_i ? ST_WB_AL : ST_WB_AH;
            ST_WB_AH: state_d = ST_WB_AL;
            ST_WB_AL: state_d = rf_mode_i ? ST_WB_CL : ST_WB_CH;
            ST_WB_CH: state_d = ST_WB_CL;
            ST_WB_CL: state_d = ST_ACK;
            ST_ACK:   state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // State register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    assign state_o = state_q;

endmodule

// File: rtl/rfp_dma_calc.sv
// Post-transfer arithmetic: address increment and count decrement.
// Assumes: in register-file mode the address is DW bits wide and the upper byte is zero.
module rfp_dma_calc #(
    parameter int DW = 8
) (
    input  logic            rf_mode_i,
    input  logic [2*DW-1:0] adr_i,
    input  logic [2*DW-1:0] cnt_i,
    output logic [2*DW-1:0] adr_nxt_o,
    output logic [2*DW-1:0] cnt_nxt_o,
    output logic            cnt_nxt_zero_o
);

    localparam int WW = 2 * DW;

    logic [WW-1:0] adr_inc_wide;
    logic [DW-1:0] adr_inc_byte;

    // Both increment widths; the mode picks the wrap point.
    always_comb begin
        adr_inc_wide = adr_i + WW'(1);
        adr_inc_byte = adr_i[DW-1:0] + DW'(1);
        adr_nxt_o    = rf_mode_i ? {{DW{1'b0}}, adr_inc_byte} : adr_inc_wide;
    end

    // Count decrement and end-of-block detection.
    always_comb begin
        cnt_nxt_o      = cnt_i - WW'(1);
        cnt_nxt_zero_o = (cnt_nxt_o == '0);
    end

endmodule

// File: rtl/rfp_dma_eob.sv
// Sticky end-of-block flag.
// Assumes: a set in the same cycle as a clear takes priority, so no event is lost.
module rfp_dma_eob (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);

    // Set on the final transfer, hold until cleared.
    always_ff @(posedge clk) begin
        if (!rst_n)     flag_o <= 1'b0;
        else if (set_i) flag_o <= 1'b1;
        else if (clr_i) flag_o <= 1'b0;
    end

endmodule

// File: rtl/rfp_dma_channel.sv
// Register-file-pointer DMA channel top.
// Fetches the address and count through pointer registers, moves one byte, writes both back,
// then acknowledges. Assumes the register file and memory answer reads combinationally and
// take writes at the clock edge. The pointers and direction are latched when a request is accepted.
module rfp_dma_channel
    import rfp_dma_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_i,
    output logic            ack_o,
    input  logic            dir_i,
    input  logic [DW-1:0]   per_wdata_i,
    output logic [DW-1:0]   per_rdata_o,
    output logic            per_we_o,
    input  logic [DW-1:0]   cnt_ptr_i,
    input  logic [DW-1:0]   adr_ptr_i,
    output logic [DW-1:0]   rf_addr_o,
    input  logic [DW-1:0]   rf_rdata_i,
    output logic            rf_we_o,
    output logic [DW-1:0]   rf_wdata_o,
    output logic [2*DW-1:0] mem_addr_o,
    input  logic [DW-1:0]   mem_rdata_i,
    output logic            mem_re_o,
    output logic            mem_we_o,
    output logic [DW-1:0]   mem_wdata_o,
    output logic            eob_o,
    input  logic            eob_clr_i
);

    localparam int WW = 2 * DW;
    localparam int PW = DW - 1;

    dma_state_e    state;
    logic          mode_q, dir_q;
    logic [PW-1:0] cbase_q, abase_q;
    logic [WW-1:0] cnt_q, adr_q;
    logic [DW-1:0] dbuf_q;
    logic          rf_mode;
    logic          cnt_zero;
    logic [WW-1:0] adr_nxt, cnt_nxt;
    logic          cnt_nxt_zero;
    logic          start;

    assign start   = (state == ST_IDLE) && req_i;
    assign rf_mode = (state == ST_IDLE) ? cnt_ptr_i[0] : mode_q;

    // Zero test on the count as it completes in ST_CNT_L.
    always_comb begin
        if (mode_q) cnt_zero = (rf_rdata_i == '0);
        else        cnt_zero = ({cnt_q[WW-1:DW], rf_rdata_i} == '0);
    end

    rfp_dma_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_i      (req_i),
        .rf_mode_i  (rf_mode),
        .cnt_zero_i (cnt_zero),
        .state_o    (state)
    );

    rfp_dma_calc #(.DW(DW)) u_calc (
        .rf_mode_i      (mode_q),
        .adr_i          (adr_q),
        .cnt_i          (cnt_q),
        .adr_nxt_o      (adr_nxt),
        .cnt_nxt_o      (cnt_nxt),
        .cnt_nxt_zero_o (cnt_nxt_zero)
    );

    rfp_dma_eob u_eob (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (ack_o && cnt_nxt_zero),
        .clr_i  (eob_clr_i),
        .flag_o (eob_o)
    );

    // Latch the request context and gather the fetched bytes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q  <= 1'b0;
            dir_q   <= 1'b0;
            cbase_q <= '0;
            abase_q <= '0;
            cnt_q   <= '0;
            adr_q   <= '0;
            dbuf_q  <= '0;
        end else begin
            if (start) begin
                mode_q  <= cnt_ptr_i[0];
                dir_q   <= dir_i;
                cbase_q <= cnt_ptr_i[DW-1:1];
                abase_q <= cnt_ptr_i[0] ? cnt_ptr_i[DW-1:1] : adr_ptr_i[DW-1:1];
                cnt_q   <= '0;
                adr_q   <= '0;
            end
            case (state)
                ST_CNT_H: cnt_q[WW-1:DW] <= rf_rdata_i;
                ST_CNT_L: cnt_q[DW-1:0]  <= rf_rdata_i;
                ST_ADR_H: adr_q[WW-1:DW] <= rf_rdata_i;
                ST_ADR_L: adr_q[DW-1:0]  <= rf_rdata_i;
                ST_XFER:  dbuf_q <= mode_q ? rf_rdata_i : mem_rdata_i;
                default:  ;
            endcase
        end
    end

    // Register-file address per sequencer step.
    always_comb begin
        unique case (state)
            ST_CNT_H, ST_WB_CH: rf_addr_o = {cbase_q, 1'b0};
            ST_CNT_L, ST_WB_CL: rf_addr_o = {cbase_q, 1'b1};
            ST_ADR_H, ST_WB_AH: rf_addr_o = {abase_q, 1'b0};
            ST_ADR_L, ST_WB_AL: rf_addr_o = {abase_q, ~mode_q};
            ST_XFER:            rf_addr_o = adr_q[DW-1:0];
            default:            rf_addr_o = {cbase_q, 1'b1};
        endcase
    end

    // Register-file write enable and data for write-back and peripheral-to-file moves.
    always_comb begin
        rf_we_o    = 1'b0;
        rf_wdata_o = per_wdata_i;
        unique case (state)
            ST_WB_AH: begin rf_we_o = 1'b1; rf_wdata_o = adr_nxt[WW-1:DW]; end
            ST_WB_AL: begin rf_we_o = 1'b1; rf_wdata_o = adr_nxt[DW-1:0];  end
            ST_WB_CH: begin rf_we_o = 1'b1; rf_wdata_o = cnt_nxt[WW-1:DW]; end
            ST_WB_CL: begin rf_we_o = 1'b1; rf_wdata_o = cnt_nxt[DW-1:0];  end
            ST_XFER:  rf_we_o = mode_q && !dir_q;
            default:  ;
        endcase
    end

    // Memory port, active only in the move step of a memory transfer.
    always_comb begin
        mem_addr_o  = adr_q;
        mem_wdata_o = per_wdata_i;
        mem_we_o    = (state == ST_XFER) && !mode_q && !dir_q;
        mem_re_o    = (state == ST_XFER) && !mode_q && dir_q;
    end

    // Peripheral side: acknowledge and load strobe.
    always_comb begin
        ack_o       = (state == ST_ACK);
        per_we_o    = ack_o && dir_q;
        per_rdata_o = dbuf_q;
    end

endmodule

// File: rtl/rfp_dma_checker.sv
// Protocol checks for the DMA channel, attached by bind.
module rfp_dma_checker (
    input logic clk,
    input logic rst_n,
    input logic ack_o,
    input logic per_we_o,
    input logic eob_o,
    input logic eob_clr_i,
    input logic rf_we_o,
    input logic mem_we_o,
    input logic mem_re_o
);

    // R8: acknowledge never lasts two cycles
    p_ack_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |=> !ack_o);

    // R4: peripheral load only with an acknowledge
    p_per_we_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
        per_we_o |-> ack_o);

    // R2: register-file and memory accesses never coincide
    p_port_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rf_we_o, mem_we_o, mem_re_o}));

    // R7: flag holds until a clear
    p_eob_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (eob_o && !eob_clr_i) |=> eob_o);

    // R7: flag rises only after an acknowledge
    p_eob_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(eob_o) |-> $past(ack_o));

    // R9: reset leaves outputs idle
    p_reset_idle_r9: assert property (@(posedge clk)
        !rst_n |=> (!ack_o && !eob_o && !rf_we_o && !mem_we_o));

endmodule

bind rfp_dma_channel rfp_dma_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ack_o     (ack_o),
    .per_we_o  (per_we_o),
    .eob_o     (eob_o),
    .eob_clr_i (eob_clr_i),
    .rf_we_o   (rf_we_o),
    .mem_we_o  (mem_we_o),
    .mem_re_o  (mem_re_o)
);

// File: tb/rfp_dma_channel_tb.sv
module rfp_dma_channel_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0, dir = 1'b0, eob_clr = 1'b0;
    logic [7:0]  per_wdata = '0, cnt_ptr = '0, adr_ptr = '0;
    logic        ack, per_we, rf_we, mem_re, mem_we, eob;
    logic [7:0]  per_rdata, rf_addr, rf_wdata, rf_rdata, mem_rdata, mem_wdata;
    logic [15:0] mem_addr;

    logic [7:0]  rf   [256];
    logic [7:0]  memm [256];
    logic [15:0] last_mw;
    int          mw_count = 0;
    int          vectors = 0, fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rfp_dma_channel u_dut (
        .clk(clk), .rst_n(rst_n), .req_i(req), .ack_o(ack), .dir_i(dir),
        .per_wdata_i(per_wdata), .per_rdata_o(per_rdata), .per_we_o(per_we),
        .cnt_ptr_i(cnt_ptr), .adr_ptr_i(adr_ptr),
        .rf_addr_o(rf_addr), .rf_rdata_i(rf_rdata), .rf_we_o(rf_we), .rf_wdata_o(rf_wdata),
        .mem_addr_o(mem_addr), .mem_rdata_i(mem_rdata), .mem_re_o(mem_re),
        .mem_we_o(mem_we), .mem_wdata_o(mem_wdata), .eob_o(eob), .eob_clr_i(eob_clr)
    );

    // Storage models: combinational read, write at the edge; memory aliased on the low byte.
    assign rf_rdata  = rf[rf_addr];
    assign mem_rdata = memm[mem_addr[7:0]];
    always @(posedge clk) begin
        if (rf_we) rf[rf_addr] <= rf_wdata;
        if (mem_we) begin
            memm[mem_addr[7:0]] <= mem_wdata;
            last_mw  <= mem_addr;
            mw_count <= mw_count + 1;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_adr(input bit rfm, input logic [15:0] a);
        return rfm ? {8'h00, a[7:0] + 8'h01} : a + 16'h0001;
    endfunction

    function automatic int exp_lat(input bit rfm);
        return rfm ? 6 : 10;
    endfunction

    task automatic clear_eob();
        @(negedge clk); eob_clr = 1'b1;
        @(negedge clk); eob_clr = 1'b0;
    endtask

    // One request; all expected values derive from the requirement text.
    task automatic do_xfer(input bit rfm, input bit d, input logic [7:0] cp, input logic [7:0] ap,
                           input logic [15:0] a, input logic [15:0] c, input logic [7:0] data);
        logic [7:0] cpair, apair, pr;
        logic [15:0] na, nc;
        int n, mw0;
        bit got, pw;
        clear_eob();
        @(negedge clk);
        cpair = {cp[7:1], 1'b0};
        apair = {ap[7:1], 1'b0};
        if (rfm) begin
            rf[cpair] = a[7:0]; rf[cpair + 8'd1] = c[7:0];
        end else begin
            rf[cpair] = c[15:8]; rf[cpair + 8'd1] = c[7:0];
            rf[apair] = a[15:8]; rf[apair + 8'd1] = a[7:0];
        end
        if (d) begin
            if (rfm) rf[a[7:0]] = data; else memm[a[7:0]] = data;
            per_wdata = ~data;
        end else begin
            if (rfm) rf[a[7:0]] = ~data; else memm[a[7:0]] = ~data;
            per_wdata = data;
        end
        cnt_ptr = {cp[7:1], rfm};
        adr_ptr = ap;
        dir = d;
        mw0 = mw_count;
        req = 1'b1;
        n = 0; got = 0; pr = '0; pw = 0;
        while (n < 30 && !got) begin
            @(posedge clk); n++;
            @(negedge clk);
            if (ack) begin got = 1; pw = per_we; pr = per_rdata; end
        end
        req = 1'b0;
        if ((rfm && c[7:0] == 8'h00) || (!rfm && c == 16'h0000)) begin
            chk("R6 no ack on zero count", {31'd0, got}, 32'd0);
            chk("R6 count untouched", {24'd0, rf[cpair + 8'd1]}, {24'd0, c[7:0]});
            chk("R6 target untouched", rfm ? {24'd0, rf[a[7:0]]} : {24'd0, memm[a[7:0]]},
                {24'd0, d ? data : ~data});
            chk("R6 no memory write", mw_count, mw0);
            return;
        end
        na = exp_adr(rfm, a);
        nc = c - 16'h0001;
        chk("R8 ack latency", n, exp_lat(rfm));
        @(negedge clk);
        chk("R8 ack one cycle", {31'd0, ack}, 32'd0);
        if (rfm) begin
            chk("R3/R5 rf address writeback", {24'd0, rf[cpair]}, {16'd0, na});
            chk("R3 rf count writeback", {24'd0, rf[cpair + 8'd1]}, {24'd0, nc[7:0]});
        end else begin
            chk("R3/R5 mem address writeback", {16'd0, rf[apair], rf[apair + 8'd1]}, {16'd0, na});
            chk("R3 mem count writeback", {16'd0, rf[cpair], rf[cpair + 8'd1]}, {16'd0, nc});
        end
        if (d) begin
            chk("R4 per_we with ack", {31'd0, pw}, 32'd1);
            chk("R4 per_rdata", {24'd0, pr}, {24'd0, data});
        end else if (rfm) begin
            chk("R1 rf target byte", {24'd0, rf[a[7:0]]}, {24'd0, data});
        end else begin
            chk("R2 mem target byte", {24'd0, memm[a[7:0]]}, {24'd0, data});
            chk("R2 mem write address", {16'd0, last_mw}, {16'd0, a});
        end
        chk("R7 eob after transfer", {31'd0, eob}, {31'd0, (rfm ? nc[7:0] == 8'h00 : nc == 16'h0000)});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        for (int i = 0; i < 256; i++) begin rf[i] = '0; memm[i] = '0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R9 ack after reset", {31'd0, ack}, 32'd0);
        chk("R9 eob after reset", {31'd0, eob}, 32'd0);
        chk("R9 writes idle after reset", {30'd0, rf_we, mem_we}, 32'd0);
        rst_n = 1'b1;

        // Directed corners
        do_xfer(1'b1, 1'b0, 8'h10, 8'h00, 16'h0040, 16'h0003, 8'hA5); // R1 basic
        do_xfer(1'b0, 1'b0, 8'h20, 8'h31, 16'h1234, 16'h0005, 8'h3C); // R2 odd address pointer
        do_xfer(1'b1, 1'b1, 8'h12, 8'h00, 16'h0050, 16'h0002, 8'h96); // R4 from rf
        do_xfer(1'b0, 1'b1, 8'h40, 8'h42, 16'hBEEF, 16'h0009, 8'h5A); // R4 from memory
        do_xfer(1'b0, 1'b0, 8'h60, 8'h62, 16'hFFFF, 16'h0001, 8'h11); // R5 16-bit wrap, R7
        do_xfer(1'b1, 1'b0, 8'h70, 8'h00, 16'h00FF, 16'h0001, 8'h22); // R5 8-bit wrap, R7
        do_xfer(1'b0, 1'b0, 8'h80, 8'h82, 16'h0100, 16'h0100, 8'h33); // 16-bit count borrow
        do_xfer(1'b1, 1'b0, 8'h90, 8'h00, 16'h0030, 16'h0000, 8'h44); // R6 rf mode
        do_xfer(1'b0, 1'b1, 8'hA0, 8'hA2, 16'h0020, 16'h0000, 8'h55); // R6 memory mode

        // R7: flag holds through idle cycles, clears on request
        do_xfer(1'b1, 1'b0, 8'hB0, 8'h00, 16'h0010, 16'h0001, 8'h66);
        repeat (5) @(negedge clk);
        chk("R7 eob holds", {31'd0, eob}, 32'd1);
        eob_clr = 1'b1; @(negedge clk); eob_clr = 1'b0;
        chk("R7 eob cleared", {31'd0, eob}, 32'd0);

        // Random mix
        for (int k = 0; k < 60; k++) begin
            bit rfm = 1'($urandom);
            bit d = 1'($urandom);
            logic [7:0] cp = 8'($urandom);
            logic [7:0] ap = 8'($urandom);
            logic [15:0] a = 16'($urandom);
            logic [15:0] c;
            while (ap[7:1] == cp[7:1]) ap = 8'($urandom);
            if (rfm) begin
                a[15:8] = 8'h00;
                while (a[7:1] == cp[7:1]) a[7:0] = 8'($urandom);
            end
            case ($urandom % 5)
                0: c = 16'h0001;
                1: c = 16'h0000;
                default: c = 16'($urandom % 700) + 16'd1;
            endcase
            if (rfm) c[15:8] = 8'h00;
            do_xfer(rfm, d, cp, ap, a, c, 8'($urandom));
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule